// File: doc/BRIEF.md
# Nested Trap Entry Unit

This unit decides, once per clock, whether the processor takes a trap and, if it does, performs the entry. A synchronous exception request carries its own trap type. Asynchronous interrupt requests arrive as a 16-bit pending vector with one bit per level. An interrupt is considered only when traps are enabled and its level is strictly above the processor interrupt level. When a trap is taken, the unit raises the trap level by one and pushes a frame into the slot for the new level. The frame holds the return PC pair, the trap type, the condition codes, the status byte and the prior trap-enable value. One cycle later the unit issues a redirect to the handler vector together with a flush.

The saved PC pair depends on the trap class. A synchronous trap saves the faulting instruction and the one after it, so the handler can re-execute the fault. An interrupt lets the current instruction complete and saves the two instructions that follow it.

A return request pops the top frame. It redirects to the saved trap PC, restores the trap-enable bit and presents the saved condition codes and status. Illegal situations move the unit into a sticky error state: a synchronous trap while traps are disabled, or any trap while the trap level is already at its maximum.

Top module: `nest_trap_unit`

## Requirements
- R1: After a synchronous reset, the unit is in its idle state. The trap level is 0, trap enable is 1, the error state is 0, and no redirect or flush is asserted.
- R2: When a trap is taken, the trap level rises by exactly one and trap enable is cleared. In the following cycle, redirect_vld and flush are each high for one cycle.
- R3: The frame at the new level holds the trap type, the condition codes, the status byte and the trap-enable value from before entry. The frame is visible on the top_* outputs.
- R4: A synchronous trap saves cur_pc as the trap PC and cur_npc as the trap next PC.
- R5: An interrupt saves cur_npc as the trap PC and cur_npc+4 as the trap next PC.
- R6: The handler vector is built as follows. Bits 31..15 are copied from tba. Bit 14 is 1 when the trap level before entry was nonzero. Bits 13..5 hold the 9-bit trap type. Bits 4..0 are zero.
- R7: An interrupt pending at a level less than or equal to pil is ignored. A taken interrupt has trap type 0x40 plus its level.
- R8: Pending interrupts are ignored while trap enable is 0.
- R9: A synchronous trap while trap enable is 0 sets a sticky error state. No redirect is issued and the trap level is unchanged. In the error state, all requests are ignored until reset.
- R10: A trap taken when the trap level equals MAX_LVL (default 5) sets the error state instead of entering. The trap level never exceeds MAX_LVL.
- R11: A synchronous request wins over any interrupt. Among eligible interrupts, the highest level wins.
- R12: A return at a nonzero trap level lowers the level by one and redirects to the saved trap PC. It restores trap enable from the frame and presents the saved condition codes and status on ret_cc and ret_stat with ret_done high. A return at trap level 0 is ignored.
- R13: A te_set pulse sets trap enable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_req | input | 1 | Synchronous exception request |
| sync_tt | input | 9 | Trap type of the synchronous request |
| irq_pend | input | 16 | Pending interrupt per level (bit n = level n) |
| pil | input | 4 | Processor interrupt level |
| te_set | input | 1 | Set trap enable |
| ret_req | input | 1 | Return-from-trap request |
| cur_pc | input | 32 | PC of the current instruction |
| cur_npc | input | 32 | Next PC |
| cur_cc | input | 8 | Current condition codes |
| cur_stat | input | 8 | Current status fields |
| tba | input | 32 | Trap base address |
| redirect_vld | output | 1 | Redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| flush | output | 1 | Annul younger instructions |
| ret_done | output | 1 | Return completed this cycle |
| ret_cc | output | 8 | Restored condition codes |
| ret_stat | output | 8 | Restored status fields |
| trap_lvl | output | 3 | Current trap level |
| trap_en | output | 1 | Trap enable |
| err_state | output | 1 | Sticky error state |
| top_tpc | output | 32 | Trap PC of the top frame |
| top_tnpc | output | 32 | Trap next PC of the top frame |
| top_tt | output | 9 | Trap type of the top frame |
| top_cc | output | 8 | Condition codes of the top frame |
| top_stat | output | 8 | Status of the top frame |
| top_en | output | 1 | Saved trap enable of the top frame |

## Verification
The hardest state to reach is the maximum-level overflow. Entry always clears trap enable, and a synchronous trap while disabled takes the other error path. The stimulus therefore climbs the levels by alternating te_set pulses with synchronous traps until the level reaches MAX_LVL, then issues one more trap with traps enabled. A return is also placed between nested entries, so that the bench can check the nested vector bit, the restored enable value and the popped frame. A second reset is then used to reach the disabled-trap error path separately.

// File: rtl/ntu_pkg.sv
// Package: shared widths, constants and the trap-state frame layout.
// Assumes a 32-bit PC and 4-byte instructions.
package ntu_pkg;
    localparam int PC_W        = 32;
    localparam int TT_W        = 9;
    localparam int CC_W        = 8;
    localparam int ST_W        = 8;
    localparam int IRQ_LEVELS  = 16;
    localparam int IRQ_LB      = $clog2(IRQ_LEVELS);
    localparam int VEC_LSB     = 5;
    localparam int NEST_BIT    = VEC_LSB + TT_W;
    localparam int INSN_BYTES  = 4;
    localparam int IRQ_TT_BASE = 'h40;

    typedef struct packed {
        logic [PC_W-1:0] tpc;
        logic [PC_W-1:0] tnpc;
        logic [TT_W-1:0] tt;
        logic [CC_W-1:0] cc;
        logic [ST_W-1:0] stat;
        logic            en;
    } frame_t;
endpackage

// File: rtl/ntu_arbiter.sv
// Module: ntu_arbiter
// Chooses at most one trap source per cycle. A synchronous request always
// wins. Otherwise the highest pending interrupt level strictly above pil
// is taken, provided traps are enabled. Purely combinational; the clock
// and reset feed only the embedded assertions.
module ntu_arbiter
    import ntu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sync_req,
    input  logic [TT_W-1:0]       sync_tt,
    input  logic [IRQ_LEVELS-1:0] irq_pend,
    input  logic [IRQ_LB-1:0]     pil,
    input  logic                  trap_en,
    output logic                  take_sync,
    output logic                  take_irq,
    output logic [TT_W-1:0]       sel_tt,
    output logic [IRQ_LB-1:0]     sel_lvl
);
    logic              irq_found;
    logic [IRQ_LB-1:0] irq_best;

    // Scan upward so the highest eligible level is the last one kept.
    always_comb begin
        irq_found = 1'b0;
        irq_best  = '0;
        for (int i = 0; i < IRQ_LEVELS; i++) begin
            if (irq_pend[i] && (i > int'(pil))) begin
                irq_found = 1'b1;
                irq_best  = IRQ_LB'(i);
            end
        end
    end

    // Resolve the winner and its trap type.
    always_comb begin
        take_sync = sync_req;
        take_irq  = !sync_req && trap_en && irq_found;
        sel_lvl   = irq_best;
        sel_tt    = sync_req ? sync_tt : (TT_W'(IRQ_TT_BASE) | TT_W'(irq_best));
    end

    assert_one_winner_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_sync, take_irq}))
        else $error("two trap sources taken together");

    assert_irq_above_pil_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (sel_lvl > pil) && trap_en && irq_pend[sel_lvl])
        else $error("interrupt taken at or below pil or while disabled");
endmodule

// File: rtl/ntu_frame_stack.sv
// Module: ntu_frame_stack
// Holds one trap-state frame per trap level (1..DEPTH). It has one write
// port at an explicit level and one combinational read port. Reading
// level 0 returns an all-zero frame.
module ntu_frame_stack
    import ntu_pkg::*;
#(
    parameter int DEPTH = 5,
    localparam int IW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  frame_t        wr_frame,
    input  logic [IW-1:0] rd_idx,
    output frame_t        rd_frame
);
    frame_t slots [1:DEPTH];

    // Store the frame for the addressed level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i <= DEPTH; i++) slots[i] <= '0;
        end else if (wr_en) begin
            for (int i = 1; i <= DEPTH; i++)
                if (wr_idx == IW'(i)) slots[i] <= wr_frame;
        end
    end

    // Present the frame at the read level.
    always_comb begin
        rd_frame = '0;
        for (int i = 1; i <= DEPTH; i++)
            if (rd_idx == IW'(i)) rd_frame = slots[i];
    end

    assert_wr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx != '0) && (wr_idx <= IW'(DEPTH)))
        else $error("frame written outside 1..DEPTH");
endmodule

// File: rtl/nest_trap_unit.sv
// Module: nest_trap_unit
// Top of the trap entry unit. It arbitrates the trap sources and builds
// the frame for the new level. It also sequences entry, return and the
// sticky error state, and issues a registered redirect with a flush.
// Assumes one request cycle per trap, and that the pipeline holds
// cur_pc/cur_npc stable during the request cycle.
module nest_trap_unit
    import ntu_pkg::*;
#(
    parameter int MAX_LVL = 5,
    localparam int LW     = $clog2(MAX_LVL + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sync_req,
    input  logic [TT_W-1:0]       sync_tt,
    input  logic [IRQ_LEVELS-1:0] irq_pend,
    input  logic [IRQ_LB-1:0]     pil,
    input  logic                  te_set,
    input  logic                  ret_req,
    input  logic [PC_W-1:0]       cur_pc,
    input  logic [PC_W-1:0]       cur_npc,
    input  logic [CC_W-1:0]       cur_cc,
    input  logic [ST_W-1:0]       cur_stat,
    input  logic [PC_W-1:0]       tba,
    output logic                  redirect_vld,
    output logic [PC_W-1:0]       redirect_pc,
    output logic                  flush,
    output logic                  ret_done,
    output logic [CC_W-1:0]       ret_cc,
    output logic [ST_W-1:0]       ret_stat,
    output logic [LW-1:0]         trap_lvl,
    output logic                  trap_en,
    output logic                  err_state,
    output logic [PC_W-1:0]       top_tpc,
    output logic [PC_W-1:0]       top_tnpc,
    output logic [TT_W-1:0]       top_tt,
    output logic [CC_W-1:0]       top_cc,
    output logic [ST_W-1:0]       top_stat,
    output logic                  top_en
);
    localparam logic [PC_W-1:0] BASE_MASK = ~((PC_W'(1) << (NEST_BIT + 1)) - PC_W'(1));

    logic              take_sync, take_irq, take_any;
    logic [TT_W-1:0]   sel_tt;
    logic [IRQ_LB-1:0] sel_lvl;
    logic              fatal, enter, leave;
    frame_t            new_frame, top_frame;
    logic [PC_W-1:0]   vec_pc;

    ntu_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_req  (sync_req),
        .sync_tt   (sync_tt),
        .irq_pend  (irq_pend),
        .pil       (pil),
        .trap_en   (trap_en),
        .take_sync (take_sync),
        .take_irq  (take_irq),
        .sel_tt    (sel_tt),
        .sel_lvl   (sel_lvl)
    );

    // Classify this cycle as error, entry, return or nothing.
    always_comb begin
        take_any = take_sync || take_irq;
        fatal    = !err_state && ((take_sync && !trap_en) ||
                                  (take_any && (trap_lvl == LW'(MAX_LVL))));
        enter    = !err_state && take_any && !fatal;
        leave    = !err_state && !take_any && ret_req && (trap_lvl != '0);
    end

    // Assemble the frame to push; the return pair depends on trap class.
    always_comb begin
        new_frame.tt   = sel_tt;
        new_frame.cc   = cur_cc;
        new_frame.stat = cur_stat;
        new_frame.en   = trap_en;
        if (take_sync) begin
            new_frame.tpc  = cur_pc;
            new_frame.tnpc = cur_npc;
        end else begin
            new_frame.tpc  = cur_npc;
            new_frame.tnpc = cur_npc + PC_W'(INSN_BYTES);
        end
    end

    // Handler vector: base bits, nested flag, trap type, zero low bits.
    always_comb begin
        vec_pc = (tba & BASE_MASK)
               | (PC_W'(trap_lvl != '0) << NEST_BIT)
               | (PC_W'(sel_tt) << VEC_LSB);
    end

    ntu_frame_stack #(.DEPTH(MAX_LVL)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (enter),
        .wr_idx   (trap_lvl + LW'(1)),
        .wr_frame (new_frame),
        .rd_idx   (trap_lvl),
        .rd_frame (top_frame)
    );

    // Sequence trap level, enable, error and the redirect outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_lvl     <= '0;
            trap_en      <= 1'b1;
            err_state    <= 1'b0;
            redirect_vld <= 1'b0;
            redirect_pc  <= '0;
            flush        <= 1'b0;
            ret_done     <= 1'b0;
            ret_cc       <= '0;
            ret_stat     <= '0;
        end else begin
            redirect_vld <= 1'b0;
            flush        <= 1'b0;
            ret_done     <= 1'b0;
            if (fatal) begin
                err_state <= 1'b1;
                flush     <= 1'b1;
            end else if (enter) begin
                trap_lvl     <= trap_lvl + LW'(1);
                trap_en      <= 1'b0;
                redirect_vld <= 1'b1;
                redirect_pc  <= vec_pc;
                flush        <= 1'b1;
            end else if (leave) begin
                trap_lvl     <= trap_lvl - LW'(1);
                trap_en      <= top_frame.en;
                redirect_vld <= 1'b1;
                redirect_pc  <= top_frame.tpc;
                flush        <= 1'b1;
                ret_done     <= 1'b1;
                ret_cc       <= top_frame.cc;
                ret_stat     <= top_frame.stat;
            end else if (te_set && !err_state) begin
                trap_en <= 1'b1;
            end
        end
    end

    // Expose the top frame.
    always_comb begin
        top_tpc  = top_frame.tpc;
        top_tnpc = top_frame.tnpc;
        top_tt   = top_frame.tt;
        top_cc   = top_frame.cc;
        top_stat = top_frame.stat;
        top_en   = top_frame.en;
    end

    assert_entry_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (trap_lvl == $past(trap_lvl) + LW'(1)) && !trap_en && redirect_vld)
        else $error("entry did not step the level");

    assert_redirect_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |-> flush)
        else $error("redirect without flush");

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_state |=> err_state && !redirect_vld)
        else $error("error state left or redirect in error");

    assert_lvl_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_lvl <= LW'(MAX_LVL))
        else $error("trap level above maximum");

    assert_ret_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        leave |=> (trap_lvl == $past(trap_lvl) - LW'(1)) && ret_done)
        else $error("return did not step the level down");
endmodule

// File: tb/sim_nest_trap_unit.sv
module sim_nest_trap_unit;
    import ntu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAXL       = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_req = 1'b0;
    logic [8:0]  sync_tt = '0;
    logic [15:0] irq_pend = '0;
    logic [3:0]  pil = '0;
    logic        te_set = 1'b0;
    logic        ret_req = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_npc = '0;
    logic [7:0]  cur_cc = '0;
    logic [7:0]  cur_stat = '0;
    logic [31:0] tba = 32'h1234_5678;
    logic        redirect_vld, flush, ret_done, trap_en, err_state, top_en;
    logic [31:0] redirect_pc, top_tpc, top_tnpc;
    logic [7:0]  ret_cc, ret_stat, top_cc, top_stat;
    logic [8:0]  top_tt;
    logic [2:0]  trap_lvl;

    nest_trap_unit #(.MAX_LVL(MAXL)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .sync_tt(sync_tt),
        .irq_pend(irq_pend), .pil(pil), .te_set(te_set), .ret_req(ret_req),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_cc(cur_cc), .cur_stat(cur_stat),
        .tba(tba), .redirect_vld(redirect_vld), .redirect_pc(redirect_pc),
        .flush(flush), .ret_done(ret_done), .ret_cc(ret_cc), .ret_stat(ret_stat),
        .trap_lvl(trap_lvl), .trap_en(trap_en), .err_state(err_state),
        .top_tpc(top_tpc), .top_tnpc(top_tnpc), .top_tt(top_tt),
        .top_cc(top_cc), .top_stat(top_stat), .top_en(top_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_q[$];
    bit          done = 1'b0;

    task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] vec(input logic [31:0] base, input logic nest, input logic [8:0] tt);
        return (base & 32'hFFFF_8000) | {17'd0, nest, tt, 5'd0};
    endfunction

    // Monitor: every redirect must match the next expected target.
    always @(negedge clk) begin
        if (rst_n && redirect_vld) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6 R12 unexpected redirect actual=%h expected=none", redirect_pc);
            end else begin
                chk(redirect_pc, exp_q.pop_front(), "R6 R12 redirect target");
            end
        end
    end

    task automatic sync_trap(input logic [8:0] tt, input logic [31:0] pc, input logic [31:0] npc,
                             input logic [7:0] cc, input logic [7:0] st);
        sync_req = 1'b1; sync_tt = tt; cur_pc = pc; cur_npc = npc; cur_cc = cc; cur_stat = st;
        @(negedge clk);
        sync_req = 1'b0;
    endtask

    task automatic irq(input logic [15:0] pend, input logic [3:0] lvl, input logic [31:0] pc,
                       input logic [31:0] npc, input logic [7:0] cc, input logic [7:0] st);
        irq_pend = pend; pil = lvl; cur_pc = pc; cur_npc = npc; cur_cc = cc; cur_stat = st;
        @(negedge clk);
        irq_pend = '0;
    endtask

    task automatic do_ret();
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
    endtask

    task automatic enable_traps();
        te_set = 1'b1;
        @(negedge clk);
        te_set = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(trap_lvl, 0, "R1 level");
        chk(trap_en, 1, "R1 enable");
        chk(err_state, 0, "R1 error");
        chk({redirect_vld, flush}, 0, "R1 redirect/flush");

        // R12 return at level 0 ignored
        do_ret();
        chk(trap_lvl, 0, "R12 return at level 0");
        chk(ret_done, 0, "R12 ret_done at level 0");

        // R2 R3 R4 R6 synchronous misaligned trap (type 0x34)
        exp_q.push_back(vec(tba, 1'b0, 9'h034));
        sync_trap(9'h034, 32'h100, 32'h104, 8'hA5, 8'h3C);
        chk(trap_lvl, 1, "R2 level after entry");
        chk(trap_en, 0, "R2 enable cleared");
        chk(flush, 1, "R2 flush");
        chk(top_tpc, 32'h100, "R4 saved pc");
        chk(top_tnpc, 32'h104, "R4 saved npc");
        chk(top_tt, 9'h034, "R3 saved type");
        chk(top_cc, 8'hA5, "R3 saved cc");
        chk(top_stat, 8'h3C, "R3 saved status");
        chk(top_en, 1, "R3 saved enable");
        @(negedge clk);
        chk(flush, 0, "R2 flush one cycle");

        // R8 interrupt while disabled
        irq(16'h0200, 4'd0, 32'h180, 32'h184, 8'h00, 8'h00);
        chk(trap_lvl, 1, "R8 level unchanged");
        chk(redirect_vld, 0, "R8 no redirect");

        // R13 enable
        enable_traps();
        chk(trap_en, 1, "R13 enable set");

        // R5 R7 R11 R6 interrupts 3, 9, 12 with pil 10: level 12 wins
        exp_q.push_back(vec(tba, 1'b1, 9'h04C));
        irq(16'h1208, 4'd10, 32'h200, 32'h204, 8'h77, 8'h12);
        chk(trap_lvl, 2, "R11 level after interrupt");
        chk(top_tt, 9'h04C, "R7 R11 interrupt type");
        chk(top_tpc, 32'h204, "R5 saved pc");
        chk(top_tnpc, 32'h208, "R5 saved npc");
        chk(top_en, 1, "R3 saved enable nested");

        // R7 level equal to pil ignored
        enable_traps();
        irq(16'h0020, 4'd5, 32'h280, 32'h284, 8'h00, 8'h00);
        chk(trap_lvl, 2, "R7 level equal pil ignored");

        // R11 sync beats interrupt
        exp_q.push_back(vec(tba, 1'b1, 9'h011));
        irq_pend = 16'h8000; pil = 4'd0;
        sync_trap(9'h011, 32'h300, 32'h304, 8'h5A, 8'h66);
        irq_pend = '0;
        chk(trap_lvl, 3, "R11 level after sync");
        chk(top_tt, 9'h011, "R11 sync type wins");

        // R12 return
        exp_q.push_back(32'h300);
        do_ret();
        chk(trap_lvl, 2, "R12 level after return");
        chk(trap_en, 1, "R12 enable restored");
        chk(ret_done, 1, "R12 ret_done");
        chk(ret_cc, 8'h5A, "R12 restored cc");
        chk(ret_stat, 8'h66, "R12 restored status");
        chk(top_tt, 9'h04C, "R12 top frame after pop");

        // R10 climb to the maximum level
        for (int k = 3; k <= MAXL; k++) begin
            exp_q.push_back(vec(tba, 1'b1, 9'h020));
            sync_trap(9'h020, 32'h400, 32'h404, 8'h01, 8'h02);
            enable_traps();
        end
        chk(trap_lvl, MAXL, "R10 at maximum");
        sync_trap(9'h021, 32'h500, 32'h504, 8'h01, 8'h02);
        chk(err_state, 1, "R10 error at maximum");
        chk(trap_lvl, MAXL, "R10 level held");
        chk(redirect_vld, 0, "R10 no redirect");
        do_ret();
        chk(trap_lvl, MAXL, "R9 return ignored in error");

        // R9 sync while disabled
        do_reset();
        chk(err_state, 0, "R1 error cleared by reset");
        exp_q.push_back(vec(tba, 1'b0, 9'h034));
        sync_trap(9'h034, 32'h600, 32'h604, 8'h00, 8'h00);
        sync_trap(9'h035, 32'h700, 32'h704, 8'h00, 8'h00);
        chk(err_state, 1, "R9 error on disabled sync");
        chk(trap_lvl, 1, "R9 level unchanged");
        chk(redirect_vld, 0, "R9 no redirect");
        enable_traps();
        chk(trap_en, 0, "R9 te_set ignored in error");

        repeat (2) @(negedge clk);
        chk(exp_q.size(), 0, "R6 all expected redirects seen");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule